// File: doc/BRIEF.md
# Auto-Ranging Gated Frequency Counter

This block measures how often an external signal rises by counting its rising edges while a gate window of a known number of system clock cycles is open. Every measurement opens with a short probe window one 2^LOG_PROBE-th of a second long. The high bits of the probe count then choose the next step. The block reports the probe count itself, or it measures again over a 1/2^LOG_MID second window or a full one-second window. This keeps the reported number inside CNT_W bits while giving the finest resolution the input rate allows.

The input is asynchronous to the system clock. It passes through a synchroniser and a rising-edge detector before it reaches the counter. Measurements run back to back with no idle cycles. Each finished measurement leaves a count and a range code on the outputs, and a strobe marks the cycle in which they change. With the default parameters (3,686,400 Hz clock, 16-bit count) the three windows are 14,400, 230,400 and 3,686,400 clocks long, and the resolutions are 256 Hz, 16 Hz and 1 Hz.

Top module: `fc_autorange_counter`

## Requirements
- R1: Each measurement starts with a probe gate of CLK_HZ>>LOG_PROBE cycles. The total cycles from one result strobe to the next (or from reset release to the first strobe) equal the probe gate alone for range 0, the probe gate plus CLK_HZ>>LOG_MID for range 1, and the probe gate plus CLK_HZ for range 2.
- R2: When the top LOG_PROBE bits of the probe count are all zero, the block measures again over a CLK_HZ-cycle gate and reports that count with range code 2.
- R3: When R2 does not apply but the top LOG_PROBE-LOG_MID bits of the probe count are zero, the block measures again over a CLK_HZ>>LOG_MID gate and reports that count with range code 1.
- R4: When neither R2 nor R3 applies, the probe count is reported with range code 0.
- R5: Only rising edges of the input advance the count. An input held high or held low gives a count of 0.
- R6: The count saturates at all ones and does not wrap.
- R7: valid_o is high for exactly one cycle per result. count_o and range_o change only in that cycle and hold between strobes.
- R8: While reset is held, valid_o, count_o and range_o are 0.
- R9: The count clears at the start of every gate, so a re-measured result contains no edges from the probe window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal whose rising edges are counted |
| count_o | output | CNT_W | Latest result count |
| range_o | output | 2 | Gate that produced the result: 0 probe, 1 mid, 2 long |
| valid_o | output | 1 | One-cycle strobe when a new result is latched |

## Verification
The assertions assume that reset is held long enough to load the gate timer and to clear the synchroniser. They also assume the gate lengths are at least two cycles, so two strobes can never be adjacent. They place no constraint on sig_in, because every behaviour they check depends only on the gate sequencing. The stimulus drives sig_in as a periodic one-cycle pulse, or as a constant level, and changes it only right after a strobe. One measurement after each change is discarded, so that every checked window sees a steady rate.

// File: rtl/fc_pkg.sv
// Shared types for the auto-ranging frequency counter.
package fc_pkg;

    // Range code reported with each result; values are visible at the port.
    typedef enum logic [1:0] {
        RNG_PROBE = 2'd0,
        RNG_MID   = 2'd1,
        RNG_LONG  = 2'd2
    } rng_e;

    // Which kind of gate is currently open.
    typedef enum logic {
        PH_PROBE = 1'b0,
        PH_FULL  = 1'b1
    } phase_e;

endpackage

// File: rtl/fc_sync_edge.sv
// Synchroniser and rising-edge detector.
// Brings an asynchronous input into the clk domain through SYNC_STAGES
// flops and emits a one-cycle pulse per low-to-high transition.
// Assumes SYNC_STAGES >= 2.
module fc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the input through the synchroniser chain and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A rise is the synchronised level high while the previous level was low.
    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/fc_gate_timer.sv
// Down-counting gate timer.
// Holds the number of gate cycles still to run; expire is high on the
// final cycle of a gate. The owner reloads it on that cycle, so the timer
// never underflows. Reset loads INIT_VAL, which starts the first gate.
module fc_gate_timer #(
    parameter int          TW       = 22,
    parameter logic [TW-1:0] INIT_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] left_q;

    // Reload at gate end, otherwise count one cycle down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= INIT_VAL;
        end else if (load) begin
            left_q <= load_val;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end

    // The last cycle of a gate is the one where no cycles remain.
    assign expire = (left_q == '0);

endmodule

// File: rtl/fc_edge_counter.sv
// Saturating edge counter.
// Counts inc pulses and sticks at all ones. next_cnt includes the current
// cycle's pulse, so the owner can latch a gate's total on its last cycle.
// A clear restarts the count at zero for the following cycle.
module fc_edge_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] next_cnt
);
    logic [CW-1:0] cnt_q;

    // Add the pulse unless the count is already at its ceiling.
    always_comb begin
        if (inc && (cnt_q != {CW{1'b1}})) begin
            next_cnt = cnt_q + 1'b1;
        end else begin
            next_cnt = cnt_q;
        end
    end

    // Restart at a gate boundary, otherwise keep the running total.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= next_cnt;
        end
    end

endmodule

// File: rtl/fc_range_pick.sv
// Range decision from a probe count.
// Long gate when the top LOG_PROBE bits are clear, mid gate when the top
// LOG_PROBE-LOG_MID bits are clear, else the probe result stands.
// Assumes 0 < LOG_MID < LOG_PROBE < CW.
module fc_range_pick
    import fc_pkg::*;
#(
    parameter int CW        = 16,
    parameter int LOG_PROBE = 8,
    parameter int LOG_MID   = 4
) (
    input  logic [CW-1:0] probe_cnt,
    output rng_e          pick
);
    localparam int LONG_SH = CW - LOG_PROBE;
    localparam int MID_SH  = CW - LOG_PROBE + LOG_MID;

    logic long_fit;
    logic mid_fit;

    // Rate is low enough for the one-second gate, or for the mid gate.
    assign long_fit = ((probe_cnt >> LONG_SH) == '0);
    assign mid_fit  = ((probe_cnt >> MID_SH) == '0);

    // Prefer the longest gate that cannot overflow.
    always_comb begin
        if (long_fit) begin
            pick = RNG_LONG;
        end else if (mid_fit) begin
            pick = RNG_MID;
        end else begin
            pick = RNG_PROBE;
        end
    end

endmodule

// File: rtl/fc_autorange_counter.sv
// Auto-ranging gated frequency counter (top).
// Runs probe gates back to back. After each probe it either publishes the
// probe count or opens a longer gate chosen by fc_range_pick, then publishes
// that count. Results appear one cycle after the final gate cycle, with a
// one-cycle valid_o strobe. Assumes all gate lengths are >= 2 cycles.
module fc_autorange_counter
    import fc_pkg::*;
#(
    parameter int CLK_HZ    = 3686400,
    parameter int CNT_W     = 16,
    parameter int LOG_PROBE = 8,
    parameter int LOG_MID   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    output logic [CNT_W-1:0] count_o,
    output logic [1:0]       range_o,
    output logic             valid_o
);
    localparam int PROBE_LEN = CLK_HZ >> LOG_PROBE;
    localparam int MID_LEN   = CLK_HZ >> LOG_MID;
    localparam int LONG_LEN  = CLK_HZ;
    localparam int TW        = $clog2(LONG_LEN + 1);
    localparam logic [TW-1:0] PROBE_LD = TW'(PROBE_LEN - 1);
    localparam logic [TW-1:0] MID_LD   = TW'(MID_LEN - 1);
    localparam logic [TW-1:0] LONG_LD  = TW'(LONG_LEN - 1);

    logic             rise;
    logic             gate_end;
    logic [CNT_W-1:0] cnt_nx;
    rng_e             pick;
    logic [TW-1:0]    reload;
    phase_e           phase_q;
    phase_e           phase_d;
    rng_e             gate_q;
    rng_e             gate_d;
    logic             publish;

    fc_sync_edge #(
        .SYNC_STAGES(2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(sig_in),
        .rise    (rise)
    );

    fc_gate_timer #(
        .TW      (TW),
        .INIT_VAL(PROBE_LD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gate_end),
        .load_val(reload),
        .expire  (gate_end)
    );

    fc_edge_counter #(
        .CW(CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (gate_end),
        .inc     (rise),
        .next_cnt(cnt_nx)
    );

    fc_range_pick #(
        .CW       (CNT_W),
        .LOG_PROBE(LOG_PROBE),
        .LOG_MID  (LOG_MID)
    ) u_pick (
        .probe_cnt(cnt_nx),
        .pick     (pick)
    );

    // Decide what follows the current gate when it ends.
    always_comb begin
        phase_d = phase_q;
        gate_d  = gate_q;
        publish = 1'b0;
        if (gate_end) begin
            if ((phase_q == PH_PROBE) && (pick != RNG_PROBE)) begin
                phase_d = PH_FULL;
                gate_d  = pick;
            end else begin
                publish = 1'b1;
                phase_d = PH_PROBE;
                gate_d  = RNG_PROBE;
            end
        end
    end

    // Length of the gate that opens next.
    always_comb begin
        case (gate_d)
            RNG_MID:  reload = MID_LD;
            RNG_LONG: reload = LONG_LD;
            default:  reload = PROBE_LD;
        endcase
    end

    // Sequencer state: probe or re-measure, and which gate is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PROBE;
            gate_q  <= RNG_PROBE;
        end else begin
            phase_q <= phase_d;
            gate_q  <= gate_d;
        end
    end

    // Latch the finished count and range, strobe valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            range_o <= RNG_PROBE;
            valid_o <= 1'b0;
        end else begin
            valid_o <= publish;
            if (publish) begin
                count_o <= cnt_nx;
                range_o <= gate_q;
            end
        end
    end

endmodule

// File: rtl/fc_autorange_checker.sv
// Property checker for fc_autorange_counter, attached by bind.
// Tracks the cycles between result strobes to check gate sequencing.
module fc_autorange_checker #(
    parameter int CLK_HZ    = 3686400,
    parameter int CNT_W     = 16,
    parameter int LOG_PROBE = 8,
    parameter int LOG_MID   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_o,
    input logic [1:0]       range_o,
    input logic             valid_o
);
    localparam int PROBE_LEN = CLK_HZ >> LOG_PROBE;
    localparam int MID_LEN   = CLK_HZ >> LOG_MID;
    localparam int GW        = $clog2(PROBE_LEN + CLK_HZ + 2);
    localparam int MID_SH    = CNT_W - LOG_PROBE + LOG_MID;

    logic [GW-1:0] gap_q;

    // Cycles since the last strobe or since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (valid_o) begin
            gap_q <= GW'(1);
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_GATE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((gap_q == GW'(PROBE_LEN) && range_o == 2'd0) ||
                     (gap_q == GW'(PROBE_LEN + MID_LEN) && range_o == 2'd1) ||
                     (gap_q == GW'(PROBE_LEN + CLK_HZ) && range_o == 2'd2))); // R1

    AST_PROBE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && range_o == 2'd0) |-> ((count_o >> MID_SH) != '0)); // R4

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(count_o) && $stable(range_o))); // R7

endmodule

bind fc_autorange_counter fc_autorange_checker #(
    .CLK_HZ   (CLK_HZ),
    .CNT_W    (CNT_W),
    .LOG_PROBE(LOG_PROBE),
    .LOG_MID  (LOG_MID)
) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .count_o(count_o),
    .range_o(range_o),
    .valid_o(valid_o)
);

// File: tb/tb_fc_autorange_counter.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor pops
// one per result strobe. Gates are shrunk: probe 128, mid 512, long 2048.
module tb_fc_autorange_counter;
    localparam int CLK_HZ    = 2048;
    localparam int CNT_W     = 8;
    localparam int LOG_PROBE = 4;
    localparam int LOG_MID   = 2;
    localparam int PROBE_N   = CLK_HZ >> LOG_PROBE;
    localparam int MID_N     = CLK_HZ >> LOG_MID;
    localparam int LONG_N    = CLK_HZ;

    typedef struct {
        bit    skip;
        int    rng;
        int    lo;
        int    hi;
        string req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sig_in;
    logic [CNT_W-1:0] count_o;
    logic [1:0]       range_o;
    logic             valid_o;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    int   gper   = 0;
    int   glevel = 0;
    bit   done   = 0;

    always #2.5 clk = ~clk;

    fc_autorange_counter #(
        .CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .LOG_PROBE(LOG_PROBE), .LOG_MID(LOG_MID)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .count_o(count_o), .range_o(range_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!valid_o);
    endtask

    // Queue a discarded transition measurement, then one with the given bounds.
    task automatic expect_next(input int rng, input int lo, input int hi, input string req);
        exp_t e;
        e.skip = 1; e.rng = 0; e.lo = 0; e.hi = 0; e.req = "";
        q.push_back(e);
        e.skip = 0; e.rng = rng; e.lo = lo; e.hi = hi; e.req = req;
        q.push_back(e);
    endtask

    // Steady pulse train of period p; the expected range is derived from
    // the probe gate as stated in R2-R4, the count from the chosen gate.
    task automatic run_period(input int p, input int rng, input string req);
        int n;
        n = (rng == 2) ? LONG_N : (rng == 1) ? MID_N : PROBE_N;
        gper = p;
        expect_next(rng, n / p, (n + p - 1) / p, req);
        repeat (2) wait_valid();
        #1;
    endtask

    // Input generator: one-cycle high pulse every gper cycles, or a level.
    initial begin
        int ph;
        ph = 0;
        sig_in = 1'b0;
        forever begin
            @(negedge clk);
            if (gper == 0) begin
                sig_in = glevel[0];
            end else begin
                ph = ph + 1;
                if (ph >= gper) ph = 0;
                sig_in = (ph == 0);
            end
        end
    end

    // Monitor: compare each result with the queue head, then check the strobe drop.
    initial begin
        exp_t e;
        logic [CNT_W-1:0] held;
        forever begin
            @(negedge clk);
            if (rst_n && valid_o) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", int'(count_o), -1);
                end else begin
                    e = q.pop_front();
                    if (!e.skip) begin
                        check(int'(range_o) == e.rng, {e.req, " range"}, int'(range_o), e.rng);
                        check(int'(count_o) >= e.lo && int'(count_o) <= e.hi,
                              {e.req, " count"}, int'(count_o), e.lo);
                        held = count_o;
                        @(negedge clk);
                        check(valid_o == 1'b0, "R7 strobe width", int'(valid_o), 0);
                        check(count_o == held, "R7 count held", int'(count_o), int'(held));
                    end
                end
            end
        end
    end

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_t e;
        rst_n = 1'b0;
        e.skip = 1; e.rng = 0; e.lo = 0; e.hi = 0; e.req = "";
        q.push_back(e);
        repeat (5) @(negedge clk);
        check(valid_o == 1'b0, "R8 valid in reset", int'(valid_o), 0);
        check(count_o == '0, "R8 count in reset", int'(count_o), 0);
        check(range_o == 2'd0, "R8 range in reset", int'(range_o), 0);
        rst_n = 1'b1;
        wait_valid();
        #1;
        run_period(2,  0, "R4 probe kept at mid threshold");
        run_period(3,  1, "R3 mid gate");
        run_period(8,  1, "R3 mid at long threshold");
        run_period(5,  1, "R3 mid gate second rate");
        run_period(9,  2, "R2 long gate just below threshold");
        run_period(20, 2, "R2 long gate slow input R9");
        // R2/R5: no edges at all.
        gper = 0; glevel = 0;
        expect_next(2, 0, 0, "R2 R5 input low");
        repeat (2) wait_valid();
        #1;
        // R5: input held high has no rising edges.
        glevel = 1;
        expect_next(2, 0, 0, "R5 input held high");
        repeat (2) wait_valid();
        #1;
        glevel = 0;
        // R6: slow during probe, fast during the long gate -> saturates.
        gper = 12;
        expect_next(2, (1 << CNT_W) - 1, (1 << CNT_W) - 1, "R6 saturation");
        wait_valid();
        repeat (300) @(negedge clk);
        gper = 2;
        wait_valid();
        #1;
        gper = 4;
        expect_next(1, 128, 128, "R3 R9 mid after saturation");
        repeat (2) wait_valid();
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule